// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This block evaluates single-precision compare instructions for a floating-point coprocessor. It takes a 32-bit instruction word and decides whether the word is a compare. It drives the two 5-bit source register indices to the register file. It then takes the two 32-bit IEEE-754 operand values that the register file returns in the same cycle.

The block classifies each operand as NaN, signalling NaN or zero. It works out the ordering relation between the operands, which is exactly one of less, equal, greater or unordered. A 4-bit condition field chooses one of sixteen predicates over that relation. The one-bit outcome is registered and offered as a write to compare-result control register 1, together with a one-cycle write strobe.

An invalid-operation flag is also registered. The flag is sticky: once set, it stays set until software pulses the clear input. The register file and the delivery of traps to the core are outside this block.

Top module: `fcmp_pred_unit`

## Requirements
- R1: An issued word is a compare only when all six of these fields hold: bits [31:28] = 0xF, bits [27:24] = 0, bits [19:16] = 0x7, bits [15:12] = 0x2, bit 3 = 0 and bit 0 = 0. An issued word that fails any of them leaves the strobe, the result bit and the invalid flag untouched.
- R2: The first source index is {bit 2, bits [11:8]}. The second source index is {bit 1, bits [7:4]}. Both indices are driven combinationally from the instruction.
- R3: A compare issued in cycle N raises `ctl_wr_en_o` for exactly cycle N+1 and updates `ctl_wr_bit_o` in that cycle. When no compare is issued, the strobe is low and the result bit holds its value.
- R4: While the strobe is high, the write index `ctl_wr_idx_o` equals 1.
- R5: The condition field is bits [23:20]. Its low three bits select the predicate: 0 never, 1 unordered, 2 equal, 3 unordered-or-equal, 4 less, 5 unordered-or-less, 6 less-or-equal, 7 not-greater. Not-greater is true for less, equal or unordered. Bit 3 of the field selects the signalling variant of the same predicate.
- R6: Predicate 0 yields 0 for any operands, but it still evaluates the operands for exceptions.
- R7: A NaN has an all-ones exponent and a non-zero mantissa. A NaN on either operand makes the relation unordered. +0 and -0 compare equal. Otherwise the operands are ordered by their real value, infinities included.
- R8: A quiet NaN (mantissa bit 22 = 1) on either operand raises invalid only for condition codes 8 to 15.
- R9: A signalling NaN (mantissa bit 22 = 0) on either operand raises invalid for all sixteen condition codes.
- R10: The invalid flag is sticky until `flag_clear_i` is pulsed. A new invalid event in the same cycle as a clear leaves the flag set.
- R11: After reset the strobe, the result bit and the invalid flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | The instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| src_a_idx_o | output | 5 | Register index of the first operand |
| src_b_idx_o | output | 5 | Register index of the second operand |
| src_a_val_i | input | 32 | First operand value from the register file |
| src_b_val_i | input | 32 | Second operand value from the register file |
| flag_clear_i | input | 1 | Software clear of the invalid flag |
| ctl_wr_en_o | output | 1 | Write strobe for the compare-result register |
| ctl_wr_idx_o | output | 4 | Control register index of the write |
| ctl_wr_bit_o | output | 1 | Registered compare result |
| invalid_flag_o | output | 1 | Sticky invalid-operation flag |

## Verification
The hardest case to reach from the ports is a clear that lands in the same cycle as a fresh invalid event, since it needs a compare and a clear on the same edge. The table pulses the clear alongside every vector. As a result, after each vector the flag shows only that compare's own event, and a vector that raises invalid also covers the coincident case.

A directed sequence without clears then shows that the flag persists across a later clean compare. A clear on its own then drops the flag. Signalling NaNs are paired with quiet codes, and quiet NaNs with both halves of the code space, to separate R8 from R9.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int FP_W      = 32;
    localparam int EXP_W     = 8;
    localparam int MAN_W     = 23;
    localparam int REG_IDX_W = 5;
    localparam int COND_W    = 4;
    localparam int INSTR_W   = 32;

    // predicate selector, low three bits of the condition field
    typedef enum logic [2:0] {
        PR_NEVER = 3'd0,
        PR_UN    = 3'd1,
        PR_EQ    = 3'd2,
        PR_UEQ   = 3'd3,
        PR_LT    = 3'd4,
        PR_ULT   = 3'd5,
        PR_LE    = 3'd6,
        PR_NGT   = 3'd7
    } pred_t;

    typedef struct packed {
        logic            sign;
        logic            is_nan;
        logic            is_snan;
        logic            is_zero;
        logic [FP_W-2:0] mag;
    } fp_class_t;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
        logic un;
    } relation_t;
endpackage

// File: rtl/fcmp_decode.sv
module fcmp_decode
    import fcmp_pkg::*;
(
    input  logic [INSTR_W-1:0]   instr_i,
    output logic                 is_cmp_o,
    output logic [REG_IDX_W-1:0] idx_a_o,
    output logic [REG_IDX_W-1:0] idx_b_o,
    output logic [COND_W-1:0]    cond_o
);
    localparam logic [3:0] OPC_PREFIX = 4'hF;
    localparam logic [3:0] OPC_MAJOR  = 4'h7;
    localparam logic [3:0] OPC_SUB    = 4'h2;

    logic prefix_ok;
    logic major_ok;
    logic sub_ok;
    logic dest_zero;
    logic tail_zero;

    always_comb begin
        prefix_ok = (instr_i[31:28] == OPC_PREFIX);
        major_ok  = (instr_i[19:16] == OPC_MAJOR);
        sub_ok    = (instr_i[15:12] == OPC_SUB);
        dest_zero = (instr_i[27:24] == 4'h0) && !instr_i[3];
        tail_zero = !instr_i[0];
        is_cmp_o  = prefix_ok && major_ok && sub_ok && dest_zero && tail_zero;
        idx_a_o   = {instr_i[2], instr_i[11:8]};
        idx_b_o   = {instr_i[1], instr_i[7:4]};
        cond_o    = instr_i[23:20];
    end
endmodule

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
(
    input  logic [FP_W-1:0] op_i,
    output fp_class_t       cls_o
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    always_comb begin
        exp_f         = op_i[FP_W-2 -: EXP_W];
        man_f         = op_i[MAN_W-1:0];
        cls_o.sign    = op_i[FP_W-1];
        cls_o.mag     = op_i[FP_W-2:0];
        cls_o.is_nan  = (&exp_f) && (|man_f);
        cls_o.is_snan = (&exp_f) && (|man_f) && !man_f[MAN_W-1];
        cls_o.is_zero = ~|op_i[FP_W-2:0];
    end
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
(
    input  fp_class_t a_i,
    input  fp_class_t b_i,
    output relation_t rel_o
);
    logic unord;
    logic same;
    logic a_below;

    always_comb begin
        unord = a_i.is_nan || b_i.is_nan;
        same  = (a_i.is_zero && b_i.is_zero) ||
                ((a_i.sign == b_i.sign) && (a_i.mag == b_i.mag));
        if (a_i.sign != b_i.sign)
            a_below = a_i.sign;
        else if (!a_i.sign)
            a_below = (a_i.mag < b_i.mag);
        else
            a_below = (a_i.mag > b_i.mag);
        rel_o.un = unord;
        rel_o.eq = !unord && same;
        rel_o.lt = !unord && !same && a_below;
        rel_o.gt = !unord && !same && !a_below;
    end
endmodule

// File: rtl/fcmp_predicate.sv
module fcmp_predicate
    import fcmp_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  relation_t         rel_i,
    input  logic              any_nan_i,
    input  logic              any_snan_i,
    output logic              hit_o,
    output logic              raise_inv_o
);
    pred_t sel;
    logic  signalling;

    always_comb begin
        sel        = pred_t'(cond_i[2:0]);
        signalling = cond_i[COND_W-1];
        unique case (sel)
            PR_NEVER: hit_o = 1'b0;
            PR_UN:    hit_o = rel_i.un;
            PR_EQ:    hit_o = rel_i.eq;
            PR_UEQ:   hit_o = rel_i.un || rel_i.eq;
            PR_LT:    hit_o = rel_i.lt;
            PR_ULT:   hit_o = rel_i.un || rel_i.lt;
            PR_LE:    hit_o = rel_i.lt || rel_i.eq;
            PR_NGT:   hit_o = !rel_i.gt;
            default:  hit_o = 1'b0;
        endcase
        // operands are inspected for every code, including "never"
        raise_inv_o = any_snan_i || (signalling && any_nan_i);
    end
endmodule

// File: rtl/fcmp_pred_unit.sv
module fcmp_pred_unit
    import fcmp_pkg::*;
#(
    parameter int CTL_IDX_W      = 4,
    parameter int RESULT_CTL_IDX = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_i,
    input  logic [INSTR_W-1:0]   instr_i,
    output logic [REG_IDX_W-1:0] src_a_idx_o,
    output logic [REG_IDX_W-1:0] src_b_idx_o,
    input  logic [FP_W-1:0]      src_a_val_i,
    input  logic [FP_W-1:0]      src_b_val_i,
    input  logic                 flag_clear_i,
    output logic                 ctl_wr_en_o,
    output logic [CTL_IDX_W-1:0] ctl_wr_idx_o,
    output logic                 ctl_wr_bit_o,
    output logic                 invalid_flag_o
);
    localparam int NUM_SRC = 2;

    typedef struct packed {
        logic wr_en;
        logic result;
        logic invalid;
    } state_t;

    state_t state_d, state_q;

    logic              is_cmp;
    logic [COND_W-1:0] cond;
    logic [FP_W-1:0]   ops [NUM_SRC];
    fp_class_t         cls [NUM_SRC];
    relation_t         rel;
    logic              hit;
    logic              raise_inv;
    logic              fire;

    fcmp_decode u_decode (
        .instr_i  (instr_i),
        .is_cmp_o (is_cmp),
        .idx_a_o  (src_a_idx_o),
        .idx_b_o  (src_b_idx_o),
        .cond_o   (cond)
    );

    assign ops[0] = src_a_val_i;
    assign ops[1] = src_b_val_i;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_cls
        fcmp_classify u_cls (
            .op_i  (ops[gi]),
            .cls_o (cls[gi])
        );
    end

    fcmp_relate u_relate (
        .a_i   (cls[0]),
        .b_i   (cls[1]),
        .rel_o (rel)
    );

    fcmp_predicate u_pred (
        .cond_i      (cond),
        .rel_i       (rel),
        .any_nan_i   (cls[0].is_nan || cls[1].is_nan),
        .any_snan_i  (cls[0].is_snan || cls[1].is_snan),
        .hit_o       (hit),
        .raise_inv_o (raise_inv)
    );

    always_comb begin
        fire            = issue_i && is_cmp;
        state_d         = state_q;
        state_d.wr_en   = fire;
        if (fire)
            state_d.result = hit;
        // a new event wins over a coincident clear
        state_d.invalid = (state_q.invalid && !flag_clear_i) || (fire && raise_inv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign ctl_wr_en_o    = state_q.wr_en;
    assign ctl_wr_bit_o   = state_q.result;
    assign invalid_flag_o = state_q.invalid;
    assign ctl_wr_idx_o   = CTL_IDX_W'(RESULT_CTL_IDX);

    // R3: strobe follows a recognised compare by one cycle
    a_r3_strobe_after_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && is_cmp) |=> ctl_wr_en_o);
    // R3: no compare, no strobe and result held
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_i && is_cmp) |=> (!ctl_wr_en_o && $stable(ctl_wr_bit_o)));
    // R6: predicate "never" yields zero
    a_r6_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && is_cmp && cond[2:0] == 3'd0) |=> !ctl_wr_bit_o);
    // R7: exactly one ordering relation holds
    a_r7_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({rel.lt, rel.eq, rel.gt, rel.un}));
    // R9: a signalling NaN sets the flag for any code
    a_r9_snan_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && is_cmp && (cls[0].is_snan || cls[1].is_snan)) |=> invalid_flag_o);
    // R10: the flag stays set without a clear
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (invalid_flag_o && !flag_clear_i) |=> invalid_flag_o);
endmodule

// File: tb/tb_fcmp_pred_unit.sv
module tb_fcmp_pred_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 21;

    localparam logic [31:0] P_ONE  = 32'h3F80_0000;
    localparam logic [31:0] P_TWO  = 32'h4000_0000;
    localparam logic [31:0] N_ONE  = 32'hBF80_0000;
    localparam logic [31:0] N_TWO  = 32'hC000_0000;
    localparam logic [31:0] P_ZERO = 32'h0000_0000;
    localparam logic [31:0] N_ZERO = 32'h8000_0000;
    localparam logic [31:0] P_INF  = 32'h7F80_0000;
    localparam logic [31:0] N_INF  = 32'hFF80_0000;
    localparam logic [31:0] Q_NAN  = 32'h7FC0_0000;
    localparam logic [31:0] S_NAN  = 32'h7F80_0001;

    // {cond, a, b, expected result, expected invalid}
    localparam logic [69:0] VEC [NVEC] = '{
        {4'h2, P_ONE,  P_ONE,         1'b1, 1'b0},
        {4'h4, P_ONE,  P_TWO,         1'b1, 1'b0},
        {4'h4, P_TWO,  P_ONE,         1'b0, 1'b0},
        {4'h6, P_ONE,  P_ONE,         1'b1, 1'b0},
        {4'h7, P_TWO,  P_ONE,         1'b0, 1'b0},
        {4'h7, Q_NAN,  P_ONE,         1'b1, 1'b0},
        {4'h1, Q_NAN,  P_ONE,         1'b1, 1'b0},
        {4'h1, P_ONE,  P_TWO,         1'b0, 1'b0},
        {4'h0, P_ONE,  P_ONE,         1'b0, 1'b0},
        {4'h8, Q_NAN,  P_ONE,         1'b0, 1'b1},
        {4'h2, P_ZERO, N_ZERO,        1'b1, 1'b0},
        {4'h4, N_INF,  N_ONE,         1'b1, 1'b0},
        {4'h4, N_ONE,  N_ZERO,        1'b1, 1'b0},
        {4'h3, P_ONE,  S_NAN,         1'b1, 1'b1},
        {4'hA, P_ONE,  Q_NAN,         1'b0, 1'b1},
        {4'hD, P_ONE,  P_TWO,         1'b1, 1'b0},
        {4'hC, N_ONE,  P_ONE,         1'b1, 1'b0},
        {4'h5, P_TWO,  Q_NAN,         1'b1, 1'b0},
        {4'h4, P_ONE,  32'h3F80_0001, 1'b1, 1'b0},
        {4'h6, P_INF,  P_INF,         1'b1, 1'b0},
        {4'h4, N_ONE,  N_TWO,         1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [31:0] instr = '0;
    logic [4:0]  idx_a;
    logic [4:0]  idx_b;
    logic [31:0] val_a = '0;
    logic [31:0] val_b = '0;
    logic        clr = 1'b0;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic        wr_bit;
    logic        inv_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcmp_pred_unit dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .issue_i        (issue),
        .instr_i        (instr),
        .src_a_idx_o    (idx_a),
        .src_b_idx_o    (idx_b),
        .src_a_val_i    (val_a),
        .src_b_val_i    (val_b),
        .flag_clear_i   (clr),
        .ctl_wr_en_o    (wr_en),
        .ctl_wr_idx_o   (wr_idx),
        .ctl_wr_bit_o   (wr_bit),
        .invalid_flag_o (inv_flag)
    );

    function automatic logic [31:0] mk_cmp(input logic [3:0] c, input logic [4:0] ia, input logic [4:0] ib);
        return {4'hF, 4'h0, c, 4'h7, 4'h2, ia[3:0], ib[3:0], 1'b0, ia[4], ib[4], 1'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue_word(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                              input logic c, input logic iss);
        @(negedge clk);
        issue = iss;
        instr = w;
        val_a = a;
        val_b = b;
        clr   = c;
        @(negedge clk);
        issue = 1'b0;
        clr   = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic prev_bit;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 strobe", 32'(wr_en), 32'd0);
        check("R11 result", 32'(wr_bit), 32'd0);
        check("R11 flag", 32'(inv_flag), 32'd0);
        rst_n = 1'b1;

        // table walk, clear pulsed with each compare
        for (int i = 0; i < NVEC; i++) begin
            issue_word(mk_cmp(VEC[i][69:66], 5'h13, 5'h0A), VEC[i][65:34], VEC[i][33:2], 1'b1, 1'b1);
            check($sformatf("R3 strobe vec %0d", i), 32'(wr_en), 32'd1);
            check($sformatf("R4 index vec %0d", i), 32'(wr_idx), 32'd1);
            check($sformatf("R5/R6/R7 result vec %0d", i), 32'(wr_bit), 32'(VEC[i][1]));
            check($sformatf("R8/R9/R10 flag vec %0d", i), 32'(inv_flag), 32'(VEC[i][0]));
        end

        // R3: strobe lasts one cycle only
        @(negedge clk);
        check("R3 strobe drops", 32'(wr_en), 32'd0);

        // R2: index formation
        @(negedge clk);
        instr = mk_cmp(4'h2, 5'h1B, 5'h04);
        #1;
        check("R2 first index", 32'(idx_a), 32'h1B);
        check("R2 second index", 32'(idx_b), 32'h04);
        instr = mk_cmp(4'h2, 5'h05, 5'h1E);
        #1;
        check("R2 first index b", 32'(idx_a), 32'h05);
        check("R2 second index b", 32'(idx_b), 32'h1E);

        // set result to 1, flag to 0, then try rejected words
        issue_word(mk_cmp(4'h2, 5'h0, 5'h1), P_ONE, P_ONE, 1'b1, 1'b1);
        prev_bit = wr_bit;
        check("R1 setup", 32'(prev_bit), 32'd1);
        for (int k = 0; k < 6; k++) begin
            logic [31:0] w;
            w = mk_cmp(4'h8, 5'h0, 5'h1);
            case (k)
                0: w[31:28] = 4'hE;
                1: w[27:24] = 4'h1;
                2: w[19:16] = 4'h6;
                3: w[15:12] = 4'h3;
                4: w[3] = 1'b1;
                default: w[0] = 1'b1;
            endcase
            issue_word(w, S_NAN, P_TWO, 1'b0, 1'b1);
            check($sformatf("R1 no strobe %0d", k), 32'(wr_en), 32'd0);
            check($sformatf("R1 flag untouched %0d", k), 32'(inv_flag), 32'd0);
            check($sformatf("R1 result held %0d", k), 32'(wr_bit), 32'(prev_bit));
        end

        // R3: valid compare without issue has no effect
        issue_word(mk_cmp(4'h8, 5'h0, 5'h1), S_NAN, P_TWO, 1'b0, 1'b0);
        check("R3 no issue strobe", 32'(wr_en), 32'd0);
        check("R3 no issue flag", 32'(inv_flag), 32'd0);
        check("R3 no issue result", 32'(wr_bit), 32'd1);

        // R10: sticky behaviour without clears
        issue_word(mk_cmp(4'h0, 5'h0, 5'h1), S_NAN, P_ONE, 1'b0, 1'b1);
        check("R9 quiet never snan", 32'(inv_flag), 32'd1);
        check("R6 never result", 32'(wr_bit), 32'd0);
        issue_word(mk_cmp(4'h2, 5'h0, 5'h1), P_ONE, P_ONE, 1'b0, 1'b1);
        check("R10 flag sticky", 32'(inv_flag), 32'd1);
        check("R10 later result", 32'(wr_bit), 32'd1);
        issue_word(32'h0, P_ONE, P_ONE, 1'b1, 1'b0);
        check("R10 clear alone", 32'(inv_flag), 32'd0);

        // R8: quiet NaN with a quiet code leaves flag clear
        issue_word(mk_cmp(4'h4, 5'h0, 5'h1), P_ONE, Q_NAN, 1'b0, 1'b1);
        check("R8 quiet code qnan", 32'(inv_flag), 32'd0);
        check("R7 unordered less", 32'(wr_bit), 32'd0);

        finish_run();
    end
endmodule